// File: doc/BRIEF.md
# Multichannel Sample Capture Buffer

This block records 16-bit converter samples from up to eight input channels into one shared on-chip store of fixed total size, and then hands the stored words to a host over a word-serial read port. The number of active channels is one, two, four or eight. The store is split evenly, so each active channel gets a record of total size divided by the channel count. On every sample strobe, all active channels are written together.

A capture is started by an arm pulse. With trigger mode off, recording begins at once. With trigger mode on, the block waits for a pulse on the external trigger input. When each channel has filled its record, a done flag rises and stays high until the next arm. The host then drains the store through a ready/valid port. It gets the whole record of channel 0 first, then channel 1, and so on, each in sample order. An empty flag tells the host when nothing is left to read.

The total size is 2^ADDR_W samples. Building with ADDR_W = 16 gives 65536 samples, which means 65536, 32768, 16384 or 8192 samples per channel. The default build uses a smaller store.

Top module: `capture_buffer`

## Requirements
- R1: A write strobe `cfg_wr` with a channel-count code of 1, 2, 4 or 8 sets the active channel count from the next cycle on. The count reads back on `active_chans`, and reset sets it to 1.
- R2: A write strobe carrying any other code (for example 0, 3 or 9) leaves `active_chans` unchanged.
- R3: With N active channels, each record holds 2^ADDR_W / N samples. `done` is high right after the clock edge that takes the last strobe of the record. It stays high until the next arm, and an arm clears it at the following edge.
- R4: Every strobe taken during a capture stores the sample of each active channel. Sample i of channel k goes to store word k·(2^ADDR_W/N)+i. Data on inactive channel lanes is never stored.
- R5: An arm with `trig_mode` low starts recording. The first strobe counted is one clocked after the arm edge.
- R6: An arm with `trig_mode` high waits for `ext_trig`, and strobes seen while waiting are not stored or counted. Recording starts with strobes after the trigger edge.
- R7: A trigger outside the waiting state is ignored. This covers a trigger before arming, one during recording and one after completion. Such a trigger neither restarts the write count nor changes `done` or the readback.
- R8: Once `done` is high, the read port presents all 2^ADDR_W words in store-word order, which is channel 0's record first and then each higher channel in sample order. `rd_valid` is never high while `done` is low.
- R9: `rd_empty` is high whenever no word is readable: before a capture completes, and after the last word is accepted. An arm restarts readback from word 0.
- R10: While `rd_valid` is high and `rd_ready` is low, the presented word and `rd_valid` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Channel-count write strobe |
| cfg_chans | input | CODE_W (4) | Requested channel count: 1, 2, 4 or 8 |
| active_chans | output | CODE_W (4) | Channel count in force |
| arm | input | 1 | Starts a new capture and clears done and readback |
| trig_mode | input | 1 | High: wait for the external trigger after arm |
| ext_trig | input | 1 | External trigger pulse |
| smp_stb | input | 1 | Sample strobe for all channels |
| smp_data | input | NCH*DW (128) | Channel k sample in bits k*DW+DW-1 down to k*DW |
| done | output | 1 | Capture complete |
| rd_ready | input | 1 | Host accepts the presented word |
| rd_valid | output | 1 | A stored word is presented |
| rd_data | output | DW (16) | Presented word |
| rd_empty | output | 1 | No stored word left to read |

## Verification
A configuration write shows on `active_chans` right after the clock edge that takes it. `done` rises right after the edge that takes the final strobe of a record. Read data is presented with no added latency, and the next word appears after each edge that completes a handshake. The bench drives every input on the falling clock edge and samples outputs on the falling edge that follows. Each result is therefore checked half a cycle after the rising edge that should produce it. `done` is also checked low one strobe before the end, which pins its timing to the exact strobe count.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } cap_state_e;

endpackage

// File: rtl/cap_cfg.sv
module cap_cfg #(
    parameter int CH_W   = 3,
    parameter int CODE_W = CH_W + 1,
    parameter int LG_W   = $clog2(CH_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CODE_W-1:0] cfg_code,
    output logic [LG_W-1:0]   lg_o
);

    typedef struct packed {
        logic [LG_W-1:0] lg;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Only a power of two up to the channel limit is taken
    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            for (int j = 0; j <= CH_W; j++) begin
                if (cfg_code == CODE_W'(1 << j)) begin
                    cfg_d.lg = LG_W'(j);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.lg <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign lg_o = cfg_q.lg;

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LG_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              trig_mode,
    input  logic              ext_trig,
    input  logic              smp_stb,
    input  logic [LG_W-1:0]   lg,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wcnt_o,
    output logic              done_o
);

    typedef struct packed {
        cap_state_e        st;
        logic [ADDR_W-1:0] wcnt;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic [ADDR_W-1:0] last_idx;

    // Record length minus one: full store shifted down by log2(channels)
    assign last_idx = {ADDR_W{1'b1}} >> lg;

    always_comb begin
        ctrl_d  = ctrl_q;
        wr_en_o = 1'b0;
        if (arm) begin
            ctrl_d.wcnt = '0;
            ctrl_d.st   = trig_mode ? ST_WAIT : ST_RUN;
        end else begin
            unique case (ctrl_q.st)
                ST_WAIT: begin
                    if (ext_trig) begin
                        ctrl_d.st = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (smp_stb) begin
                        wr_en_o = 1'b1;
                        if (ctrl_q.wcnt == last_idx) begin
                            ctrl_d.st = ST_DONE;
                        end else begin
                            ctrl_d.wcnt = ctrl_q.wcnt + 1'b1;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.st   <= ST_IDLE;
            ctrl_q.wcnt <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign wcnt_o = ctrl_q.wcnt;
    assign done_o = (ctrl_q.st == ST_DONE);

endmodule

// File: rtl/cap_wmux.sv
module cap_wmux #(
    parameter int ADDR_W = 10,
    parameter int DW     = 16,
    parameter int NCH    = 8,
    parameter int CH_W   = $clog2(NCH),
    parameter int LG_W   = $clog2(CH_W + 1),
    parameter int BANK_W = ADDR_W - CH_W
) (
    input  logic                           wr_en,
    input  logic [LG_W-1:0]                lg,
    input  logic [ADDR_W-1:0]              wcnt,
    input  logic [NCH*DW-1:0]              smp_data,
    output logic [NCH-1:0]                 bank_we,
    output logic [NCH-1:0][BANK_W-1:0]     bank_wa,
    output logic [NCH-1:0][DW-1:0]         bank_wd
);

    // Store word for channel k: region base k*record_length plus write count
    function automatic logic [ADDR_W-1:0] chan_addr(input int k,
                                                    input logic [LG_W-1:0] l,
                                                    input logic [ADDR_W-1:0] w);
        logic [ADDR_W-1:0] base;
        base = ADDR_W'(k);
        return (base << (ADDR_W - int'(l))) | w;
    endfunction

    logic [ADDR_W-1:0] addr_k [NCH];
    logic [NCH-1:0]    act_k;

    always_comb begin
        bank_we = '0;
        bank_wa = '0;
        bank_wd = '0;
        for (int k = 0; k < NCH; k++) begin
            act_k[k]  = (k < (32'd1 << lg));
            addr_k[k] = chan_addr(k, lg, wcnt);
            // Active regions occupy disjoint banks, so no two channels collide
            if (wr_en && act_k[k]) begin
                bank_we[addr_k[k][ADDR_W-1 -: CH_W]] = 1'b1;
                bank_wa[addr_k[k][ADDR_W-1 -: CH_W]] = addr_k[k][BANK_W-1:0];
                bank_wd[addr_k[k][ADDR_W-1 -: CH_W]] = smp_data[k*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/cap_bank.sv
module cap_bank #(
    parameter int AW = 7,
    parameter int DW = 16,
    parameter int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[wa] <= wd;
        end
    end

    assign rd = mem_q[ra];

endmodule

// File: rtl/cap_rdport.sv
module cap_rdport #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              done,
    input  logic              rd_ready,
    output logic [ADDR_W-1:0] raddr_o,
    output logic              rd_valid_o,
    output logic              rd_empty_o
);

    typedef struct packed {
        logic [ADDR_W:0] cnt;
    } rd_t;

    rd_t rd_d, rd_q;
    logic drained;

    assign drained    = rd_q.cnt[ADDR_W];
    assign rd_valid_o = done && !drained;
    assign rd_empty_o = !rd_valid_o;
    assign raddr_o    = rd_q.cnt[ADDR_W-1:0];

    always_comb begin
        rd_d = rd_q;
        if (arm) begin
            rd_d.cnt = '0;
        end else if (rd_valid_o && rd_ready) begin
            rd_d.cnt = rd_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q.cnt <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

endmodule

// File: rtl/capture_buffer.sv
module capture_buffer #(
    parameter int ADDR_W = 10,
    parameter int DW     = 16,
    parameter int NCH    = 8,
    localparam int CH_W   = $clog2(NCH),
    localparam int CODE_W = CH_W + 1,
    localparam int LG_W   = $clog2(CH_W + 1),
    localparam int BANK_W = ADDR_W - CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CODE_W-1:0] cfg_chans,
    output logic [CODE_W-1:0] active_chans,
    input  logic              arm,
    input  logic              trig_mode,
    input  logic              ext_trig,
    input  logic              smp_stb,
    input  logic [NCH*DW-1:0] smp_data,
    output logic              done,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              rd_empty
);

    logic [LG_W-1:0]               lg;
    logic                          wr_en;
    logic [ADDR_W-1:0]             wcnt;
    logic [NCH-1:0]                bank_we;
    logic [NCH-1:0][BANK_W-1:0]    bank_wa;
    logic [NCH-1:0][DW-1:0]        bank_wd;
    logic [ADDR_W-1:0]             raddr;
    logic [DW-1:0]                 bank_rd [NCH];

    cap_cfg #(.CH_W(CH_W), .CODE_W(CODE_W), .LG_W(LG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_code (cfg_chans),
        .lg_o     (lg)
    );

    assign active_chans = CODE_W'(1) << lg;

    cap_ctrl #(.ADDR_W(ADDR_W), .LG_W(LG_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .trig_mode (trig_mode),
        .ext_trig  (ext_trig),
        .smp_stb   (smp_stb),
        .lg        (lg),
        .wr_en_o   (wr_en),
        .wcnt_o    (wcnt),
        .done_o    (done)
    );

    cap_wmux #(.ADDR_W(ADDR_W), .DW(DW), .NCH(NCH), .CH_W(CH_W),
               .LG_W(LG_W), .BANK_W(BANK_W)) u_wmux (
        .wr_en    (wr_en),
        .lg       (lg),
        .wcnt     (wcnt),
        .smp_data (smp_data),
        .bank_we  (bank_we),
        .bank_wa  (bank_wa),
        .bank_wd  (bank_wd)
    );

    for (genvar b = 0; b < NCH; b++) begin : g_bank
        cap_bank #(.AW(BANK_W), .DW(DW)) u_bank (
            .clk (clk),
            .we  (bank_we[b]),
            .wa  (bank_wa[b]),
            .wd  (bank_wd[b]),
            .ra  (raddr[BANK_W-1:0]),
            .rd  (bank_rd[b])
        );
    end

    cap_rdport #(.ADDR_W(ADDR_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .done       (done),
        .rd_ready   (rd_ready),
        .raddr_o    (raddr),
        .rd_valid_o (rd_valid),
        .rd_empty_o (rd_empty)
    );

    assign rd_data = bank_rd[raddr[ADDR_W-1 -: CH_W]];

endmodule

// File: rtl/cap_buffer_chk.sv
module cap_buffer_chk #(
    parameter int NCH    = 8,
    parameter int DW     = 16,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [CODE_W-1:0] cfg_chans,
    input logic [CODE_W-1:0] active_chans,
    input logic              arm,
    input logic              ext_trig,
    input logic              done,
    input logic              rd_ready,
    input logic              rd_valid,
    input logic [DW-1:0]     rd_data,
    input logic              rd_empty
);

    logic code_ok;
    assign code_ok = ($countones(cfg_chans) == 1) && (int'(cfg_chans) <= NCH);

    a_r1_count_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(active_chans) == 1);

    a_r2_bad_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !code_ok |=> $stable(active_chans));

    a_r3_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        done && !arm |=> done);

    a_r7_trig_keeps_done: assert property (@(posedge clk) disable iff (!rst_n)
        done && ext_trig && !arm |=> done);

    a_r8_valid_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> done);

    a_r9_arm_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !done && rd_empty);

    a_r10_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready && !arm |=> rd_valid && $stable(rd_data));

endmodule

bind capture_buffer cap_buffer_chk #(.NCH(NCH), .DW(DW), .CODE_W(CODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_chans    (cfg_chans),
    .active_chans (active_chans),
    .arm          (arm),
    .ext_trig     (ext_trig),
    .done         (done),
    .rd_ready     (rd_ready),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .rd_empty     (rd_empty)
);

// File: tb/capture_buffer_bench.sv
`timescale 1ns/1ps
module capture_buffer_bench;

    localparam int ADDR_W = 10;
    localparam int DW     = 16;
    localparam int NCH    = 8;
    localparam int TOTAL  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [3:0]        cfg_chans = 4'd0;
    logic [3:0]        active_chans;
    logic              arm = 1'b0;
    logic              trig_mode = 1'b0;
    logic              ext_trig = 1'b0;
    logic              smp_stb = 1'b0;
    logic [NCH*DW-1:0] smp_data = '0;
    logic              done;
    logic              rd_ready = 1'b0;
    logic              rd_valid;
    logic [DW-1:0]     rd_data;
    logic              rd_empty;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    capture_buffer #(.ADDR_W(ADDR_W), .DW(DW), .NCH(NCH)) u_capture_buffer (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_chans(cfg_chans),
        .active_chans(active_chans), .arm(arm), .trig_mode(trig_mode),
        .ext_trig(ext_trig), .smp_stb(smp_stb), .smp_data(smp_data),
        .done(done), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_empty(rd_empty)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int k, input int i);
        return DW'((k << 12) | (i & 12'hfff));
    endfunction

    function automatic logic [NCH*DW-1:0] frame(input int i);
        logic [NCH*DW-1:0] f;
        for (int k = 0; k < NCH; k++) f[k*DW +: DW] = pat(k, i);
        return f;
    endfunction

    task automatic write_cfg(input int code);
        cfg_wr = 1'b1;
        cfg_chans = 4'(code);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk(active_chans == 4'd1, "R1", "reset channel count", active_chans, 1);
        chk(done == 1'b0, "R3", "reset done", done, 0);
        chk(rd_empty == 1'b1 && rd_valid == 1'b0, "R9", "reset empty", rd_empty, 1);
    endtask

    task automatic t_config();
        write_cfg(4);
        chk(active_chans == 4'd4, "R1", "legal code 4", active_chans, 4);
        write_cfg(3);
        chk(active_chans == 4'd4, "R2", "code 3 rejected", active_chans, 4);
        write_cfg(0);
        chk(active_chans == 4'd4, "R2", "code 0 rejected", active_chans, 4);
        write_cfg(9);
        chk(active_chans == 4'd4, "R2", "code 9 rejected", active_chans, 4);
        write_cfg(8);
        chk(active_chans == 4'd8, "R1", "legal code 8", active_chans, 8);
    endtask

    // Capture one record set and drain it; checks R3..R10 along the way
    task automatic t_capture(input int code, input bit use_trig);
        int len;
        int bad;
        int first_idx;
        int first_act;
        int first_exp;
        logic [DW-1:0] exp;
        len = TOTAL / code;
        write_cfg(code);
        chk(active_chans == 4'(code), "R1", "count set", active_chans, code);
        trig_mode = use_trig;
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        chk(done == 1'b0 && rd_empty == 1'b1, "R9", "arm clears done", done, 0);
        if (use_trig) begin
            smp_data = {NCH{16'hdead}};
            for (int j = 0; j < 3; j++) begin
                smp_stb = 1'b1;
                @(negedge clk);
            end
            smp_stb = 1'b0;
            chk(done == 1'b0, "R6", "waiting ignores strobes", done, 0);
            ext_trig = 1'b1;
            @(negedge clk);
            ext_trig = 1'b0;
        end
        for (int i = 0; i < len; i++) begin
            smp_stb  = 1'b1;
            smp_data = frame(i);
            if (use_trig && i == len / 2) ext_trig = 1'b1;
            @(negedge clk);
            smp_stb  = 1'b0;
            ext_trig = 1'b0;
            smp_data = {NCH{16'hbeef}};
            if (i == len - 2) chk(done == 1'b0, "R3", "done low one strobe early", done, 0);
            if (i == len - 1) chk(done == 1'b1, "R3", "done after last strobe", done, 1);
            @(negedge clk);
        end
        chk(done == 1'b1, "R3", "done holds", done, 1);
        if (use_trig) begin
            ext_trig = 1'b1;
            @(negedge clk);
            ext_trig = 1'b0;
            @(negedge clk);
            chk(done == 1'b1 && rd_data == pat(0, 0), "R7", "late trigger ignored",
                rd_data, pat(0, 0));
        end
        bad = 0;
        first_idx = -1;
        first_act = 0;
        first_exp = 0;
        rd_ready = 1'b1;
        for (int idx = 0; idx < TOTAL; idx++) begin
            exp = pat(idx / len, idx % len);
            if (idx == 5) begin
                rd_ready = 1'b0;
                for (int s = 0; s < 3; s++) begin
                    @(negedge clk);
                    chk(rd_valid && rd_data == exp, "R10", "stall holds word", rd_data, exp);
                end
                rd_ready = 1'b1;
            end
            if (!(rd_valid && rd_data == exp)) begin
                bad++;
                if (first_idx < 0) begin
                    first_idx = idx;
                    first_act = rd_data;
                    first_exp = exp;
                end
            end
            @(negedge clk);
        end
        rd_ready = 1'b0;
        chk(bad == 0, "R4", $sformatf("store content, first bad word %0d", first_idx),
            first_act, first_exp);
        chk(bad == 0, "R8", "readback order and count", bad, 0);
        if (!use_trig) chk(bad == 0, "R5", "immediate start", bad, 0);
        else           chk(bad == 0, "R6", "trigger start", bad, 0);
        chk(rd_empty == 1'b1 && rd_valid == 1'b0, "R9", "drained empty", rd_empty, 1);
    endtask

    task automatic t_idle_trigger();
        trig_mode = 1'b1;
        ext_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        chk(done == 1'b1 && rd_empty == 1'b1, "R7", "trigger without arm ignored", done, 1);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        chk(done == 1'b0 && rd_empty == 1'b1, "R9", "arm clears after drain", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_capture(1, 1'b0);
        t_capture(2, 1'b1);
        t_capture(4, 1'b0);
        t_capture(8, 1'b1);
        t_idle_trigger();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule